// File: doc/BRIEF.md
# Cache Hit/Miss Access Predictor

This block guesses, ahead of each cache lookup, whether that lookup will hit. A lookup engine uses the guess to pick its access style. A predicted hit leads to reading only the expected way, tag and data together. A predicted miss leads to the two-step phased style: all tags are compared first, and data is read only after a match. The engine presents the set index of the coming access and gets a one-bit guess back in the same cycle. When an access resolves, the engine reports its set and whether it really hit, and the block trains on that report.

A parameter picks one of four prediction schemes:
- a lone 2-bit saturating counter shared by every set;
- a table of 2-bit counters indexed by a global record of the last K outcomes;
- the same table indexed by a record kept separately for each set;
- the table indexed by the global record XORed with the set index.

Two 16-bit saturating counters tally resolved accesses and correct guesses.

Top module: `hitmiss_predictor`

## Requirements
- R1: After reset every 2-bit counter holds 2 (weakly hit), every history register is zero and both tallies are zero, so the guess is hit for any set.
- R2: `pred_hit_o` is the upper bit of the counter selected for `acc_set_i` (1 = hit, way-predicted access; 0 = miss, phased access). It is combinational from `acc_set_i` and the stored state.
- R3: A counter trained with a hit steps up by one and stops at 3. A counter trained with a miss steps down by one and stops at 0.
- R4: With MODE = 0 a single counter serves every set.
- R5: With MODE = 1 the table index is a K-bit global history. Each outcome enters at bit 0 (1 = hit, 0 = miss) and older outcomes move one place toward the upper bit.
- R6: With MODE = 2 each set keeps its own K-bit history, shifted the same way. The history of the set being looked up indexes one table shared by all sets.
- R7: With MODE = 3 the table index is the global history XORed with the set index, zero-extended or truncated to K bits.
- R8: On a report (`res_valid_i` = 1) the block first trains the counter that `res_set_i` selects under the current state. It then shifts the outcome into the relevant history. The new state shows from the next cycle.
- R9: While `res_valid_i` is 0, no counter, history or tally changes.
- R10: Each report adds one to the total tally. It adds one to the correct tally when the trained counter's upper bit equals the outcome. Both tallies stop at 65535.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_set_i | input | SET_W | Set index of the coming access |
| res_valid_i | input | 1 | A resolved access is being reported |
| res_hit_i | input | 1 | Outcome of the reported access, 1 = hit |
| res_set_i | input | SET_W | Set index of the reported access |
| pred_hit_o | output | 1 | Guess for `acc_set_i`, 1 = hit |
| correct_cnt_o | output | CNT_W | Saturating tally of correct guesses |
| total_cnt_o | output | CNT_W | Saturating tally of reports |

## Verification
The guess is due in the same cycle that `acc_set_i` is driven. The bench drives inputs on the falling edge and reads `pred_hit_o` 1 ns later, before the rising edge that takes in the report. A report changes counters, histories and tallies at that rising edge. So the bench applies the matching update to its own model only after the edge, and the tallies and guesses are first compared on the following falling edge. All four schemes run side by side on the same stimulus, so a fault in any one scheme's indexing shows up as a wrong guess one cycle after the report that exposes it.

// File: rtl/hitmiss_predictor.sv
module hitmiss_predictor #(
  parameter int MODE   = 3,
  parameter int HIST_W = 6,
  parameter int SETS   = 16,
  parameter int CNT_W  = 16,
  localparam int SET_W = $clog2(SETS),
  localparam int PHT_N = 1 << HIST_W,
  localparam int MW    = (SET_W < HIST_W) ? SET_W : HIST_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] acc_set_i,
  input  logic             res_valid_i,
  input  logic             res_hit_i,
  input  logic [SET_W-1:0] res_set_i,
  output logic             pred_hit_o,
  output logic [CNT_W-1:0] correct_cnt_o,
  output logic [CNT_W-1:0] total_cnt_o
);

  logic [1:0]        pht_q   [PHT_N];
  logic [HIST_W-1:0] shist_q [SETS];
  logic [HIST_W-1:0] ghist_q;
  logic [HIST_W-1:0] acc_ext, res_ext, acc_idx, res_idx;
  logic [1:0]        res_ctr, res_nxt;
  logic [CNT_W-1:0]  tot_q, cor_q;

  assign acc_ext = HIST_W'(acc_set_i[MW-1:0]);
  assign res_ext = HIST_W'(res_set_i[MW-1:0]);

  assign acc_idx = (MODE == 0) ? '0 :
                   (MODE == 1) ? ghist_q :
                   (MODE == 2) ? shist_q[acc_set_i] : (ghist_q ^ acc_ext);
  assign res_idx = (MODE == 0) ? '0 :
                   (MODE == 1) ? ghist_q :
                   (MODE == 2) ? shist_q[res_set_i] : (ghist_q ^ res_ext);

  assign pred_hit_o = pht_q[acc_idx][1];
  assign res_ctr    = pht_q[res_idx];
  assign res_nxt    = res_hit_i ? ((res_ctr == 2'd3) ? 2'd3 : res_ctr + 2'd1)
                                : ((res_ctr == 2'd0) ? 2'd0 : res_ctr - 2'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < PHT_N; i++) pht_q[i] <= 2'd2;
      for (int i = 0; i < SETS; i++) shist_q[i] <= '0;
      ghist_q <= '0;
      tot_q   <= '0;
      cor_q   <= '0;
    end else if (res_valid_i) begin
      pht_q[res_idx]     <= res_nxt;
      ghist_q            <= {ghist_q[HIST_W-2:0], res_hit_i};
      shist_q[res_set_i] <= {shist_q[res_set_i][HIST_W-2:0], res_hit_i};
      if (tot_q != '1) tot_q <= tot_q + 1'b1;
      if (res_ctr[1] == res_hit_i && cor_q != '1) cor_q <= cor_q + 1'b1;
    end
  end

  assign correct_cnt_o = cor_q;
  assign total_cnt_o   = tot_q;

  // R10
  tally_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_i && total_cnt_o != '1) |=> total_cnt_o == $past(total_cnt_o) + 1'b1);

  // R10
  tally_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (total_cnt_o == '1) |=> total_cnt_o == '1);

  // R10
  tally_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    correct_cnt_o <= total_cnt_o);

  // R9
  tally_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid_i |=> ($stable(total_cnt_o) && $stable(correct_cnt_o)));

  // R9
  pred_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!res_valid_i ##1 $stable(acc_set_i)) |-> $stable(pred_hit_o));

endmodule

// File: tb/test_hitmiss_predictor.sv
`timescale 1ns/1ps
module test_hitmiss_predictor;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] acc_set = '0, res_set = '0;
  logic res_valid = 1'b0, res_hit = 1'b0;
  logic pred [4];
  logic [15:0] cor [4];
  logic [15:0] tot [4];
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  hitmiss_predictor #(.MODE(3)) i_hitmiss_predictor (.clk(clk), .rst_n(rst_n),
    .acc_set_i(acc_set), .res_valid_i(res_valid), .res_hit_i(res_hit), .res_set_i(res_set),
    .pred_hit_o(pred[3]), .correct_cnt_o(cor[3]), .total_cnt_o(tot[3]));
  hitmiss_predictor #(.MODE(0)) i_hitmiss_predictor_m0 (.clk(clk), .rst_n(rst_n),
    .acc_set_i(acc_set), .res_valid_i(res_valid), .res_hit_i(res_hit), .res_set_i(res_set),
    .pred_hit_o(pred[0]), .correct_cnt_o(cor[0]), .total_cnt_o(tot[0]));
  hitmiss_predictor #(.MODE(1)) i_hitmiss_predictor_m1 (.clk(clk), .rst_n(rst_n),
    .acc_set_i(acc_set), .res_valid_i(res_valid), .res_hit_i(res_hit), .res_set_i(res_set),
    .pred_hit_o(pred[1]), .correct_cnt_o(cor[1]), .total_cnt_o(tot[1]));
  hitmiss_predictor #(.MODE(2)) i_hitmiss_predictor_m2 (.clk(clk), .rst_n(rst_n),
    .acc_set_i(acc_set), .res_valid_i(res_valid), .res_hit_i(res_hit), .res_set_i(res_set),
    .pred_hit_o(pred[2]), .correct_cnt_o(cor[2]), .total_cnt_o(tot[2]));

  // reference model built from R1..R10
  int m_pht [4][64];
  int m_gh  [4];
  int m_sh  [4][16];
  int m_tot [4];
  int m_cor [4];

  function automatic int m_idx(int md, int s);
    case (md)
      0: return 0;
      1: return m_gh[md];
      2: return m_sh[md][s];
      default: return m_gh[md] ^ s;
    endcase
  endfunction

  task automatic model_reset();
    for (int md = 0; md < 4; md++) begin
      for (int i = 0; i < 64; i++) m_pht[md][i] = 2;
      for (int i = 0; i < 16; i++) m_sh[md][i] = 0;
      m_gh[md] = 0; m_tot[md] = 0; m_cor[md] = 0;
    end
  endtask

  task automatic model_update(bit v, bit h, int us);
    if (!v) return;
    for (int md = 0; md < 4; md++) begin
      int ix, c;
      ix = m_idx(md, us);
      c  = m_pht[md][ix];
      if (((c >> 1) & 1) == int'(h) && m_cor[md] < 65535) m_cor[md]++;
      if (m_tot[md] < 65535) m_tot[md]++;
      m_pht[md][ix] = h ? ((c == 3) ? 3 : c + 1) : ((c == 0) ? 0 : c - 1);
      m_gh[md] = ((m_gh[md] << 1) | int'(h)) & 63;
      m_sh[md][us] = ((m_sh[md][us] << 1) | int'(h)) & 63;
    end
  endtask

  task automatic chk(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // R2 R4 R5 R6 R7 R10: compare every scheme against the model
  task automatic check_all();
    for (int md = 0; md < 4; md++) begin
      chk($sformatf("R2/R%0d pred mode%0d", 4 + md, md), int'(pred[md]),
          (m_pht[md][m_idx(md, int'(acc_set))] >> 1) & 1);
      chk($sformatf("R10 total mode%0d", md), int'(tot[md]), m_tot[md]);
      chk($sformatf("R10 correct mode%0d", md), int'(cor[md]), m_cor[md]);
    end
  endtask

  task automatic step(int s, bit v, bit h, int us);
    @(negedge clk);
    acc_set = 4'(s); res_valid = v; res_hit = h; res_set = 4'(us);
    #1 check_all();
    @(posedge clk);
    model_update(v, h, us);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; res_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    model_reset();
  endtask

  // {acc_set[3:0], valid, hit, res_set[3:0]}
  localparam logic [9:0] VEC [24] = '{
    {4'd0, 1'b1, 1'b0, 4'd0}, {4'd0, 1'b1, 1'b0, 4'd0}, {4'd1, 1'b1, 1'b1, 4'd1},
    {4'd5, 1'b1, 1'b0, 4'd5}, {4'd5, 1'b0, 1'b1, 4'd5}, {4'd5, 1'b1, 1'b0, 4'd5},
    {4'd9, 1'b1, 1'b1, 4'd9}, {4'd9, 1'b1, 1'b1, 4'd9}, {4'd15, 1'b1, 1'b0, 4'd15},
    {4'd15, 1'b0, 1'b0, 4'd3}, {4'd3, 1'b1, 1'b1, 4'd3}, {4'd3, 1'b1, 1'b0, 4'd7},
    {4'd7, 1'b1, 1'b0, 4'd7}, {4'd7, 1'b1, 1'b0, 4'd7}, {4'd2, 1'b1, 1'b1, 4'd2},
    {4'd2, 1'b0, 1'b0, 4'd2}, {4'd2, 1'b1, 1'b1, 4'd12}, {4'd12, 1'b1, 1'b0, 4'd12},
    {4'd12, 1'b1, 1'b1, 4'd0}, {4'd0, 1'b1, 1'b1, 4'd0}, {4'd0, 1'b1, 1'b1, 4'd0},
    {4'd8, 1'b1, 1'b0, 4'd8}, {4'd8, 1'b0, 1'b1, 4'd8}, {4'd4, 1'b1, 1'b0, 4'd4}
  };

  initial begin
    logic [15:0] lfsr;
    model_reset();
    do_reset();

    // R1: reset state, every set guesses hit, tallies zero
    for (int s = 0; s < 16; s += 5) step(s, 1'b0, 1'b0, 0);

    // table of vectors, all schemes against the model (R3 R5 R6 R7 R8 R9)
    for (int i = 0; i < 24; i++)
      step(int'(VEC[i][9:6]), VEC[i][5], VEC[i][4], int'(VEC[i][3:0]));
    step(0, 1'b0, 1'b0, 0);

    // R7: zero-extended set index; two misses on set 5 only hurt set 5 in gshare
    do_reset();
    step(5, 1'b1, 1'b0, 5);
    step(5, 1'b1, 1'b0, 5);
    @(negedge clk); acc_set = 4'd5; res_valid = 1'b0; #1;
    chk("R7 gshare set5 miss", int'(pred[3]), 0);
    chk("R5 global shared entry", int'(pred[1]), 0);
    chk("R6 per-set shared entry", int'(pred[2]), 0);
    acc_set = 4'd4; #1;
    chk("R7 gshare set4 still hit", int'(pred[3]), 1);
    chk("R4 single counter any set", int'(pred[0]), 0);

    // R3: single counter saturates at 3 then at 0
    do_reset();
    for (int i = 0; i < 3; i++) step(0, 1'b1, 1'b1, 0);
    step(0, 1'b1, 1'b0, 0);
    @(negedge clk); res_valid = 1'b0; #1;
    chk("R3 saturated at 3 then one miss", int'(pred[0]), 1);
    for (int i = 0; i < 4; i++) step(0, 1'b1, 1'b0, 0);
    step(0, 1'b1, 1'b1, 0);
    @(negedge clk); res_valid = 1'b0; #1;
    chk("R3 saturated at 0 then one hit", int'(pred[0]), 0);
    step(0, 1'b1, 1'b1, 0);
    step(0, 1'b0, 1'b0, 0);
    chk("R3 two hits up from 0", int'(pred[0]), 1);

    // long run with computed stimulus against the model
    lfsr = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(int'(lfsr[3:0]), lfsr[4] | lfsr[5], lfsr[6] | lfsr[9], int'(lfsr[11:8]));
    end
    step(0, 1'b0, 1'b0, 0);

    // R10: tallies stop at 65535
    do_reset();
    @(negedge clk); res_valid = 1'b1; res_hit = 1'b1; res_set = 4'd0;
    repeat (65540) @(negedge clk);
    res_hit = 1'b0;
    @(negedge clk); res_valid = 1'b0; #1;
    for (int md = 0; md < 4; md++) begin
      chk("R10 total saturates", int'(tot[md]), 65535);
      chk("R10 correct saturates", int'(cor[md]), 65535);
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(150000 * 20);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule